// File: doc/BRIEF.md
# Record Source Selector with Copy Gating

This block picks the stream of samples that goes to the host during recording. Two stereo sources are offered: samples from the local converter, and samples recovered by a digital audio receiver. The recovered stream is taken only when the receiver is locked and its format can be used. Its copy status must also show an original recording, and the conversion the host asks for must be one the block allows. In every other case the converter stream is recorded.

The host picks a record rate, a sample width (8 or 16 bits) and mono or stereo. The chosen pair is shaped to that format and registered with a valid strobe. A flag tells which source produced it. When the receiver is locked but its format check fails, the converter is used instead and a sticky error flag is set. The flag stays set until the host changes its requested format. Each strobe carries a complete left/right pair, so no output frame can hold samples from both sources.

Top module: `rec_src_sel`

## Requirements
- R1: The receiver stream is chosen (`rec_src_link_o` = 1 on its frames) only when all of these hold: the receiver is locked, its format is usable, its copy status is original, and the error flag is clear. Otherwise the converter stream is chosen (`rec_src_link_o` = 0).
- R2: The receiver format is usable only when all of these hold: `link_s16_i` = 1 (16-bit stereo); the rate code is 0 (48 kHz), 1 (44.1 kHz) or 2 (32 kHz); and `host_rate_i` equals `link_rate_i`. Rate codes 3 to 7 are unusable.
- R3: A non-zero `link_gen_i` (first generation or later copy) forces the converter stream. A value of 0 means original.
- R4: With `host_mono_i` = 1, `rec_left_o` carries (L+R)>>>1 computed in two's complement without overflow, and `rec_right_o` is 0.
- R5: With `host_narrow_i` = 1, the sample is reduced to its upper 8 bits. These bits are placed in bits 7:0, and bits 15:8 are 0. Mono and narrow together narrow the mono mix.
- R6: If the receiver is locked and the host asks for mono and narrow at the same time, the receiver format counts as unusable.
- R7: If the receiver is locked and its format is unusable, `fmt_err_o` goes to 1. It stays at 1 until the host format {rate, narrow, mono} changes. While it is 1, the converter stream is chosen.
- R8: A strobe from the source that is not selected produces no output and leaves the output data unchanged. A strobe from the selected source produces one output frame one cycle later. A change of source inputs takes effect for strobes that arrive two cycles after the change.
- R9: While reset is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_valid_i | input | 1 | Converter pair strobe |
| conv_left_i | input | 16 | Converter left sample |
| conv_right_i | input | 16 | Converter right sample |
| link_valid_i | input | 1 | Receiver pair strobe |
| link_left_i | input | 16 | Receiver left sample |
| link_right_i | input | 16 | Receiver right sample |
| link_lock_i | input | 1 | Receiver locked |
| link_rate_i | input | 3 | Detected receiver rate code |
| link_s16_i | input | 1 | Receiver data is 16-bit stereo |
| link_gen_i | input | 2 | Copy generation, 0 = original |
| host_rate_i | input | 3 | Requested record rate code |
| host_narrow_i | input | 1 | Requested 8-bit samples |
| host_mono_i | input | 1 | Requested mono |
| rec_valid_o | output | 1 | Output pair strobe |
| rec_left_o | output | 16 | Output left or mono sample |
| rec_right_o | output | 16 | Output right sample |
| rec_src_link_o | output | 1 | Output frame came from the receiver |
| fmt_err_o | output | 1 | Sticky format error |

## Verification
The error flag updates one edge after its inputs change. The source choice follows one edge after that. A formatted frame appears one edge after the strobe that carries it. For each case the bench changes the static inputs on a falling edge and waits two rising edges. It then raises both strobes for one cycle and samples the outputs on the next falling edge, where frame, source flag and error flag are all settled. Directed cases check that the output holds when only the unselected strobe is raised, and that the valid strobe lasts exactly one cycle.

// File: rtl/rec_src_pkg.sv
package rec_src_pkg;
  localparam int RATE_W = 3;

  typedef enum logic [RATE_W-1:0] {
    RATE_48K    = 3'd0,
    RATE_44K1   = 3'd1,
    RATE_32K    = 3'd2,
    RATE_22K05  = 3'd3,
    RATE_16K    = 3'd4,
    RATE_11K025 = 3'd5,
    RATE_8K     = 3'd6,
    RATE_RSVD   = 3'd7
  } rate_e;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic              narrow;
    logic              mono;
  } rec_fmt_t;

  function automatic logic link_rate_ok(input logic [RATE_W-1:0] code);
    case (rate_e'(code))
      RATE_48K, RATE_44K1, RATE_32K: return 1'b1;
      default:                       return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/rec_fmt_check.sv
module rec_fmt_check
  import rec_src_pkg::*;
#(
  parameter int GEN_W = 2
) (
  input  logic [RATE_W-1:0] link_rate_i,
  input  logic              link_s16_i,
  input  logic [GEN_W-1:0]  link_gen_i,
  input  rec_fmt_t          host_fmt_i,
  output logic              fmt_bad_o,
  output logic              original_o
);
  logic rate_bad;

  assign rate_bad   = !link_rate_ok(link_rate_i) || (link_rate_i != host_fmt_i.rate);
  // only one conversion step is allowed on received data
  assign fmt_bad_o  = rate_bad || !link_s16_i || (host_fmt_i.mono && host_fmt_i.narrow);
  assign original_o = (link_gen_i == '0);
endmodule

// File: rtl/rec_fmt_conv.sv
module rec_fmt_conv #(
  parameter int SAMPLE_W = 16,
  parameter int NARROW_W = 8
) (
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic                mono_i,
  input  logic                narrow_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o
);
  localparam int PAD_W = SAMPLE_W - NARROW_W;

  logic [SAMPLE_W:0]   sum;
  logic [SAMPLE_W-1:0] mix, l_sel, r_sel, l_nar, r_nar;

  assign sum   = {left_i[SAMPLE_W-1], left_i} + {right_i[SAMPLE_W-1], right_i};
  assign mix   = sum[SAMPLE_W:1];
  assign l_sel = mono_i ? mix : left_i;
  assign r_sel = mono_i ? '0  : right_i;

  generate
    if (PAD_W > 0) begin : g_pad
      assign l_nar = {{PAD_W{1'b0}}, l_sel[SAMPLE_W-1 -: NARROW_W]};
      assign r_nar = {{PAD_W{1'b0}}, r_sel[SAMPLE_W-1 -: NARROW_W]};
    end else begin : g_full
      assign l_nar = l_sel;
      assign r_nar = r_sel;
    end
  endgenerate

  assign left_o  = narrow_i ? l_nar : l_sel;
  assign right_o = narrow_i ? r_nar : r_sel;
endmodule

// File: rtl/rec_src_sel.sv
module rec_src_sel
  import rec_src_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int NARROW_W = 8,
  parameter int GEN_W    = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                conv_valid_i,
  input  logic [SAMPLE_W-1:0] conv_left_i,
  input  logic [SAMPLE_W-1:0] conv_right_i,
  input  logic                link_valid_i,
  input  logic [SAMPLE_W-1:0] link_left_i,
  input  logic [SAMPLE_W-1:0] link_right_i,
  input  logic                link_lock_i,
  input  logic [RATE_W-1:0]   link_rate_i,
  input  logic                link_s16_i,
  input  logic [GEN_W-1:0]    link_gen_i,
  input  logic [RATE_W-1:0]   host_rate_i,
  input  logic                host_narrow_i,
  input  logic                host_mono_i,
  output logic                rec_valid_o,
  output logic [SAMPLE_W-1:0] rec_left_o,
  output logic [SAMPLE_W-1:0] rec_right_o,
  output logic                rec_src_link_o,
  output logic                fmt_err_o
);
  rec_fmt_t            host_fmt, host_prev_q;
  logic                fmt_bad, original, host_chg, want_link;
  logic                err_q, src_q;
  logic                sel_valid;
  logic [SAMPLE_W-1:0] sel_left, sel_right, fmt_left, fmt_right;
  logic                out_valid_q, out_src_q;
  logic [SAMPLE_W-1:0] out_left_q, out_right_q;

  assign host_fmt = '{rate: host_rate_i, narrow: host_narrow_i, mono: host_mono_i};

  rec_fmt_check #(.GEN_W(GEN_W)) u_check (
    .link_rate_i (link_rate_i),
    .link_s16_i  (link_s16_i),
    .link_gen_i  (link_gen_i),
    .host_fmt_i  (host_fmt),
    .fmt_bad_o   (fmt_bad),
    .original_o  (original)
  );

  assign host_chg  = (host_fmt != host_prev_q);
  assign want_link = link_lock_i && !fmt_bad && original && !err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      host_prev_q <= '0;
      err_q       <= 1'b0;
      src_q       <= 1'b0;
    end else begin
      host_prev_q <= host_fmt;
      err_q       <= host_chg ? 1'b0 : (err_q || (link_lock_i && fmt_bad));
      src_q       <= want_link;
    end
  end

  // source is fixed per pair: a strobe carries a whole L/R pair
  assign sel_valid = src_q ? link_valid_i : conv_valid_i;
  assign sel_left  = src_q ? link_left_i  : conv_left_i;
  assign sel_right = src_q ? link_right_i : conv_right_i;

  rec_fmt_conv #(.SAMPLE_W(SAMPLE_W), .NARROW_W(NARROW_W)) u_conv (
    .left_i   (sel_left),
    .right_i  (sel_right),
    .mono_i   (host_mono_i),
    .narrow_i (host_narrow_i),
    .left_o   (fmt_left),
    .right_o  (fmt_right)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      out_src_q   <= 1'b0;
      out_left_q  <= '0;
      out_right_q <= '0;
    end else begin
      out_valid_q <= sel_valid;
      if (sel_valid) begin
        out_src_q   <= src_q;
        out_left_q  <= fmt_left;
        out_right_q <= fmt_right;
      end
    end
  end

  assign rec_valid_o    = out_valid_q;
  assign rec_left_o     = out_left_q;
  assign rec_right_o    = out_right_q;
  assign rec_src_link_o = out_src_q;
  assign fmt_err_o      = err_q;
endmodule

// File: rtl/rec_src_sel_chk.sv
module rec_src_sel_chk #(
  parameter int SAMPLE_W = 16,
  parameter int NARROW_W = 8,
  parameter int GEN_W    = 2,
  parameter int RATE_W   = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                conv_valid_i,
  input logic                link_valid_i,
  input logic                link_lock_i,
  input logic [GEN_W-1:0]    link_gen_i,
  input logic [RATE_W-1:0]   host_rate_i,
  input logic                host_narrow_i,
  input logic                host_mono_i,
  input logic                rec_valid_o,
  input logic [SAMPLE_W-1:0] rec_left_o,
  input logic [SAMPLE_W-1:0] rec_right_o,
  input logic                rec_src_link_o,
  input logic                fmt_err_o
);
  // R8
  link_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && rec_src_link_o |-> $past(link_valid_i));
  // R8
  conv_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && !rec_src_link_o |-> $past(conv_valid_i));
  // R3
  copy_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && rec_src_link_o |-> $past(link_gen_i, 2) == '0);
  // R6
  no_dual_conv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && rec_src_link_o |-> !($past(host_mono_i, 2) && $past(host_narrow_i, 2)));
  // R4
  mono_right_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && $past(host_mono_i) |-> rec_right_o == '0);
  // R5
  narrow_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && $past(host_narrow_i) |->
      rec_left_o[SAMPLE_W-1:NARROW_W] == '0 && rec_right_o[SAMPLE_W-1:NARROW_W] == '0);
  // R7
  err_set_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fmt_err_o) |-> $past(link_lock_i));
  // R7
  err_clear_host_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fmt_err_o) |->
      ($past(host_rate_i) != $past(host_rate_i, 2)) ||
      ($past(host_narrow_i) != $past(host_narrow_i, 2)) ||
      ($past(host_mono_i) != $past(host_mono_i, 2)));
endmodule

bind rec_src_sel rec_src_sel_chk #(
  .SAMPLE_W(SAMPLE_W), .NARROW_W(NARROW_W), .GEN_W(GEN_W), .RATE_W(rec_src_pkg::RATE_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .conv_valid_i   (conv_valid_i),
  .link_valid_i   (link_valid_i),
  .link_lock_i    (link_lock_i),
  .link_gen_i     (link_gen_i),
  .host_rate_i    (host_rate_i),
  .host_narrow_i  (host_narrow_i),
  .host_mono_i    (host_mono_i),
  .rec_valid_o    (rec_valid_o),
  .rec_left_o     (rec_left_o),
  .rec_right_o    (rec_right_o),
  .rec_src_link_o (rec_src_link_o),
  .fmt_err_o      (fmt_err_o)
);

// File: tb/rec_src_sel_tb.sv
module rec_src_sel_tb;
  localparam logic [15:0] CONV_L = 16'h1234, CONV_R = 16'h5678;
  localparam logic [15:0] LINK_L = 16'h8000, LINK_R = 16'h7FFE;

  typedef struct packed {
    logic       lock;
    logic [2:0] lrate;
    logic       s16;
    logic [1:0] gen;
    logic [2:0] hrate;
    logic       nar;
    logic       mono;
    logic       exp_src;
    logic       exp_err;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd0, 1'b1, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R1 unlocked
    '{1'b1, 3'd0, 1'b1, 2'd0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0}, // R1 locked original
    '{1'b1, 3'd0, 1'b1, 2'd1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 first generation
    '{1'b1, 3'd0, 1'b1, 2'd0, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0}, // R4 mono from link
    '{1'b1, 3'd0, 1'b1, 2'd0, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0}, // R5 narrow from link
    '{1'b1, 3'd0, 1'b1, 2'd0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b1}, // R6 both conversions
    '{1'b0, 3'd0, 1'b1, 2'd0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b1}, // R7 sticky, host same
    '{1'b1, 3'd0, 1'b1, 2'd0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0}, // R7 cleared by host change
    '{1'b1, 3'd0, 1'b1, 2'd0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1}, // R2 rate mismatch
    '{1'b1, 3'd1, 1'b1, 2'd0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1}, // R7 sticky though usable
    '{1'b1, 3'd2, 1'b1, 2'd0, 3'd2, 1'b0, 1'b0, 1'b1, 1'b0}, // R2 32 kHz usable
    '{1'b1, 3'd3, 1'b1, 2'd0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b1}, // R2 rate code 3 unusable
    '{1'b1, 3'd0, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1}, // R2 not 16-bit stereo
    '{1'b1, 3'd2, 1'b1, 2'd2, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0}  // R3 later generation
  };

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        conv_valid_i = 0, link_valid_i = 0, link_lock_i = 0, link_s16_i = 0;
  logic [15:0] conv_left_i = CONV_L, conv_right_i = CONV_R;
  logic [15:0] link_left_i = LINK_L, link_right_i = LINK_R;
  logic [2:0]  link_rate_i = 0, host_rate_i = 0;
  logic [1:0]  link_gen_i = 0;
  logic        host_narrow_i = 0, host_mono_i = 0;
  logic        rec_valid_o, rec_src_link_o, fmt_err_o;
  logic [15:0] rec_left_o, rec_right_o;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #5ns clk_i = ~clk_i;

  rec_src_sel u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [15:0] l, input logic [15:0] r,
                                input logic nar, input logic mono,
                                output logic [15:0] ol, output logic [15:0] orr);
    int s;
    logic [15:0] a, b;
    s = (int'($signed(l)) + int'($signed(r))) >>> 1;
    a = mono ? s[15:0] : l;
    b = mono ? 16'h0 : r;
    ol  = nar ? {8'h00, a[15:8]} : a;
    orr = nar ? {8'h00, b[15:8]} : b;
  endfunction

  task automatic run_vec(input vec_t v);
    logic [15:0] el, er;
    string dreq;
    @(negedge clk_i);
    link_lock_i = v.lock; link_rate_i = v.lrate; link_s16_i = v.s16; link_gen_i = v.gen;
    host_rate_i = v.hrate; host_narrow_i = v.nar; host_mono_i = v.mono;
    @(negedge clk_i);
    @(negedge clk_i);
    conv_valid_i = 1; link_valid_i = 1;
    @(negedge clk_i);
    conv_valid_i = 0; link_valid_i = 0;
    if (v.exp_src) model(LINK_L, LINK_R, v.nar, v.mono, el, er);
    else           model(CONV_L, CONV_R, v.nar, v.mono, el, er);
    dreq = v.mono ? "R4" : (v.nar ? "R5" : "R1");
    check("R8 valid", 32'(rec_valid_o), 32'd1);
    check("R1 source", 32'(rec_src_link_o), 32'(v.exp_src));
    check("R7 error", 32'(fmt_err_o), 32'(v.exp_err));
    check({dreq, " left"}, 32'(rec_left_o), 32'(el));
    check({dreq, " right"}, 32'(rec_right_o), 32'(er));
  endtask

  initial begin
    #2ms;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R9 reset state
    repeat (2) @(negedge clk_i);
    check("R9 valid", 32'(rec_valid_o), 0);
    check("R9 left", 32'(rec_left_o), 0);
    check("R9 right", 32'(rec_right_o), 0);
    check("R9 source", 32'(rec_src_link_o), 0);
    check("R9 error", 32'(fmt_err_o), 0);
    rst_ni = 1;

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R8 unselected strobe ignored: link selected, only converter strobes
    run_vec(VECS[1]);
    @(negedge clk_i);
    check("R8 one-cycle valid", 32'(rec_valid_o), 0);
    conv_left_i = 16'hAAAA; conv_right_i = 16'h5555; conv_valid_i = 1;
    @(negedge clk_i);
    conv_valid_i = 0;
    check("R8 ignored valid", 32'(rec_valid_o), 0);
    check("R8 held left", 32'(rec_left_o), 32'(LINK_L));
    check("R8 held right", 32'(rec_right_o), 32'(LINK_R));
    check("R8 held source", 32'(rec_src_link_o), 1);

    // R4 R5 mono and narrow together on the converter stream
    conv_left_i = CONV_L; conv_right_i = CONV_R;
    run_vec(VECS[5]);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule